// File: doc/BRIEF.md
# Two-Lane Bunch-by-Bunch Feedback Datapath

This block turns beam position samples into kicker corrections, one correction per bunch. Two interleaved 12-bit converters each sample at half the bunch rate. The fabric clock also runs at half the bunch rate, so every cycle carries two bunches: the even lane holds bunch 2p and the odd lane holds bunch 2p+1. A turn marker restarts the pair count p at zero. Because the harmonic number is even, a given bunch arrives on the same lane on every turn.

Each lane runs the same three stages. The first is an FIR filter over the same bunch's samples from successive turns. The second multiplies the filtered value by a gain taken from a table with one entry per bunch. This lets selected bunches be driven, damped or left alone. The third is a delay of zero to three whole turns. At every stage the arithmetic is rounded and clamped. The two lane results leave as a rising-edge word and a falling-edge word, which feed a DDR output register outside the block. That register drives a DAC at the full bunch rate.

Software loads the coefficients, the gain table and the turn delay through a simple write port.

Top module: `fbk_top`

## Requirements
- R1: While reset is held, and after it is released, both output words are 0. Reset also clears all sample history, the delay storage, every coefficient, every gain and the turn delay.
- R2: The pair index is 0 in any cycle where `turn_mark` is 1. Otherwise it is the previous cycle's index plus one, and it wraps to 0 after HARMONIC/2-1. The first cycle after reset is pair 0. The even lane processes bunch 2p and the odd lane processes bunch 2p+1.
- R3: For bunch b in turn n, the filter output is the sum over j = 0..NTAPS-1 of c[j]·x(b, n-j). Each coefficient c[j] is a signed 16-bit value scaled by 2^-14. The sum is rounded half up (add 2^13, then an arithmetic shift right by 14) and clamped to [-2048, 2047]. History that has not yet been filled counts as 0.
- R4: The filter output of bunch b is multiplied by gain[b], a signed 16-bit value scaled by 2^-12. The product is rounded half up (add 2^11, then shift right by 12) and clamped to [-2048, 2047].
- R5: With a turn delay d of 0 to 3, the correction output for bunch b in turn n is the scaled result of that bunch from turn n-d. The delay is taken from bits [1:0] of the data written to it.
- R6: `ddr_rise` carries the even-lane result and `ddr_fall` carries the odd-lane result. A sample pair applied before clock edge k appears on the outputs after edge k+2.
- R7: The write map is as follows. Address 0x00+j writes coefficient j (for j < NTAPS). Address 0x40 writes the turn delay. Address 0x80+b writes the gain of bunch b (for b < HARMONIC). Writes to any other address have no effect. A write takes effect for samples applied in the cycles after the write cycle. The sample applied in the write cycle itself still uses the old value.
- R8: When an intermediate result overflows, it clamps to 2047 or -2048 and never wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, at half the bunch rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| turn_mark | input | 1 | High in the cycle that carries bunches 0 and 1 |
| samp_even | input | 12 | Signed sample of the even bunch (earlier in the cycle) |
| samp_odd | input | 12 | Signed sample of the odd bunch |
| cfg_we | input | 1 | Write strobe of the configuration port |
| cfg_addr | input | 8 | Configuration write address |
| cfg_wdata | input | 16 | Configuration write data |
| ddr_rise | output | 12 | Even-bunch correction, for the rising edge of the DDR stage |
| ddr_fall | output | 12 | Odd-bunch correction, for the falling edge of the DDR stage |

## Verification
The hardest state to reach from the ports is a delay buffer that holds several turns of results from a filter with full history. The bench reaches it only by running the stream for many turns. Two further conditions need deliberate stimulus: clamping at the filter and the gain stages, and a turn marker arriving mid-turn. The stimulus streams multi-turn sinusoidal bunch patterns under several coefficient sets, gain tables and delays, including overdriven coefficients that force clamping. It also raises an early turn marker and mixes configuration writes, some to unmapped addresses, into a running stream. A cycle-exact model in the bench checks every output word.

// File: rtl/fbk_pkg.sv
package fbk_pkg;
  localparam int SAMP_W    = 12;
  localparam int COEF_W    = 16;
  localparam int GAIN_W    = 16;
  localparam int COEF_FRAC = 14;
  localparam int GAIN_FRAC = 12;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 16;
  localparam int MAX_DLY   = 3;
  localparam int DLY_W     = 2;
  localparam int SAMP_MAX  = (2 ** (SAMP_W - 1)) - 1;
  localparam int SAMP_MIN  = -(2 ** (SAMP_W - 1));
  localparam logic [ADDR_W-1:0] ADDR_DLY = 8'h40;

  typedef logic signed [SAMP_W-1:0] samp_t;
  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [GAIN_W-1:0] gain_t;
endpackage

// File: rtl/fbk_cfg.sv
// Configuration registers: coefficients, per-bunch gains, turn delay (R7)
module fbk_cfg
  import fbk_pkg::*;
#(
  parameter int NTAPS    = 4,
  parameter int HARMONIC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output coef_t             coef [NTAPS],
  output gain_t             gain [HARMONIC],
  output logic [DLY_W-1:0]  dly
);
  coef_t            coef_n [NTAPS];
  gain_t            gain_n [HARMONIC];
  logic [DLY_W-1:0] dly_n;
  logic             coef_hit, gain_hit, dly_hit;

  always_comb begin
    coef_hit = we && (addr[7:6] == 2'b00) && (int'(addr[5:0]) < NTAPS);
    gain_hit = we && addr[7] && (int'(addr[6:0]) < HARMONIC);
    dly_hit  = we && (addr == ADDR_DLY);
    for (int j = 0; j < NTAPS; j++) begin
      coef_n[j] = coef[j];
      if (coef_hit && (addr[5:0] == 6'(j))) coef_n[j] = coef_t'(wdata);
    end
    for (int b = 0; b < HARMONIC; b++) begin
      gain_n[b] = gain[b];
      if (gain_hit && (addr[6:0] == 7'(b))) gain_n[b] = gain_t'(wdata);
    end
    dly_n = dly_hit ? wdata[DLY_W-1:0] : dly;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NTAPS; j++) coef[j] <= '0;
      for (int b = 0; b < HARMONIC; b++) gain[b] <= '0;
      dly <= '0;
    end else begin
      coef <= coef_n;
      gain <= gain_n;
      dly  <= dly_n;
    end
  end
endmodule

// File: rtl/fbk_fir.sv
// Turn-to-turn FIR on one lane, history held per bunch pair (R3)
module fbk_fir
  import fbk_pkg::*;
#(
  parameter int NPAIR = 8,
  parameter int NTAPS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NPAIR)-1:0] pair,
  input  samp_t                    x,
  input  coef_t                    coef [NTAPS],
  output samp_t                    fir_q
);
  localparam int ACC_W = SAMP_W + COEF_W + $clog2(NTAPS) + 1;
  localparam int SH_W  = ACC_W - COEF_FRAC;

  samp_t                   hist [NPAIR][NTAPS-1];
  samp_t                   tap  [NTAPS];
  logic signed [ACC_W-1:0] acc, acc_r;
  logic signed [SH_W-1:0]  scaled;
  samp_t                   fir_d;

  always_comb begin
    tap[0] = x;
    for (int j = 1; j < NTAPS; j++) tap[j] = hist[pair][j-1];
    acc = '0;
    for (int j = 0; j < NTAPS; j++)
      acc = acc + ACC_W'(tap[j]) * ACC_W'(coef[j]);
    acc_r  = acc + (ACC_W'(1) <<< (COEF_FRAC - 1));
    scaled = SH_W'(acc_r >>> COEF_FRAC);
    if (scaled > SH_W'(SAMP_MAX))      fir_d = samp_t'(SAMP_MAX);
    else if (scaled < SH_W'(SAMP_MIN)) fir_d = samp_t'(SAMP_MIN);
    else                               fir_d = samp_t'(scaled);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fir_q <= '0;
      for (int p = 0; p < NPAIR; p++)
        for (int j = 0; j < NTAPS - 1; j++) hist[p][j] <= '0;
    end else begin
      fir_q         <= fir_d;
      hist[pair][0] <= x;
      for (int j = 1; j < NTAPS - 1; j++) hist[pair][j] <= hist[pair][j-1];
    end
  end
endmodule

// File: rtl/fbk_scale.sv
// Per-bunch gain multiply with rounding and clamp (R4, R8)
module fbk_scale
  import fbk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  samp_t fir,
  input  gain_t gain,
  output samp_t corr_q
);
  localparam int PROD_W = SAMP_W + GAIN_W + 1;
  localparam int SH_W   = PROD_W - GAIN_FRAC;

  logic signed [PROD_W-1:0] prod, prod_r;
  logic signed [SH_W-1:0]   scaled;
  samp_t                    corr_d;

  always_comb begin
    prod   = PROD_W'(fir) * PROD_W'(gain);
    prod_r = prod + (PROD_W'(1) <<< (GAIN_FRAC - 1));
    scaled = SH_W'(prod_r >>> GAIN_FRAC);
    if (scaled > SH_W'(SAMP_MAX))      corr_d = samp_t'(SAMP_MAX);
    else if (scaled < SH_W'(SAMP_MIN)) corr_d = samp_t'(SAMP_MIN);
    else                               corr_d = samp_t'(scaled);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) corr_q <= '0;
    else        corr_q <= corr_d;
  end
endmodule

// File: rtl/fbk_delay.sv
// Whole-turn delay, a per-bunch line of past results (R5)
module fbk_delay
  import fbk_pkg::*;
#(
  parameter int NPAIR = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NPAIR)-1:0] pair,
  input  logic [DLY_W-1:0]         dly,
  input  samp_t                    corr,
  output samp_t                    out_q
);
  samp_t line [NPAIR][MAX_DLY];
  samp_t out_d;

  always_comb begin
    out_d = corr;
    for (int d = 1; d <= MAX_DLY; d++)
      if (dly == DLY_W'(d)) out_d = line[pair][d-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      for (int p = 0; p < NPAIR; p++)
        for (int d = 0; d < MAX_DLY; d++) line[p][d] <= '0;
    end else begin
      out_q         <= out_d;
      line[pair][0] <= corr;
      for (int d = 1; d < MAX_DLY; d++) line[pair][d] <= line[pair][d-1];
    end
  end
endmodule

// File: rtl/fbk_top.sv
// Two-lane bunch-by-bunch feedback datapath, DDR lane words out (R6)
module fbk_top
  import fbk_pkg::*;
#(
  parameter int HARMONIC = 16,
  parameter int NTAPS    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     turn_mark,
  input  logic signed [SAMP_W-1:0] samp_even,
  input  logic signed [SAMP_W-1:0] samp_odd,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  output logic signed [SAMP_W-1:0] ddr_rise,
  output logic signed [SAMP_W-1:0] ddr_fall
);
  localparam int NPAIR  = HARMONIC / 2;
  localparam int PAIR_W = $clog2(NPAIR);
  localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(NPAIR - 1);

  logic rst_meta, srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  coef_t            coef [NTAPS];
  gain_t            gain [HARMONIC];
  logic [DLY_W-1:0] dly;

  fbk_cfg #(.NTAPS(NTAPS), .HARMONIC(HARMONIC)) u_cfg (
    .clk(clk), .rst_n(srst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .coef(coef), .gain(gain), .dly(dly)
  );

  // pair counter (R2): pair_s1 resets to the last pair so the first cycle is pair 0
  logic [PAIR_W-1:0] pair_cur, pair_s1, pair_s2;
  logic [DLY_W-1:0]  dly_s1, dly_s2;

  always_comb begin
    if (turn_mark)                 pair_cur = '0;
    else if (pair_s1 == LAST_PAIR) pair_cur = '0;
    else                           pair_cur = pair_s1 + 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pair_s1 <= LAST_PAIR;
      pair_s2 <= '0;
      dly_s1  <= '0;
      dly_s2  <= '0;
    end else begin
      pair_s1 <= pair_cur;
      pair_s2 <= pair_s1;
      dly_s1  <= dly;
      dly_s2  <= dly_s1;
    end
  end

  samp_t x_in   [2];
  samp_t fir_w  [2];
  samp_t corr_w [2];
  samp_t out_w  [2];
  gain_t gain_s1 [2];

  assign x_in[0] = samp_even;
  assign x_in[1] = samp_odd;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    localparam logic LANE_BIT = 1'(l);

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) gain_s1[l] <= '0;
      else         gain_s1[l] <= gain[{pair_cur, LANE_BIT}];
    end

    fbk_fir #(.NPAIR(NPAIR), .NTAPS(NTAPS)) u_fir (
      .clk(clk), .rst_n(srst_n), .pair(pair_cur), .x(x_in[l]),
      .coef(coef), .fir_q(fir_w[l])
    );

    fbk_scale u_scale (
      .clk(clk), .rst_n(srst_n), .fir(fir_w[l]), .gain(gain_s1[l]),
      .corr_q(corr_w[l])
    );

    fbk_delay #(.NPAIR(NPAIR)) u_dly (
      .clk(clk), .rst_n(srst_n), .pair(pair_s2), .dly(dly_s2),
      .corr(corr_w[l]), .out_q(out_w[l])
    );
  end

  assign ddr_rise = out_w[0];
  assign ddr_fall = out_w[1];
endmodule

// File: rtl/fbk_chk.sv
module fbk_chk
  import fbk_pkg::*;
#(
  parameter int NPAIR  = 8,
  parameter int PAIR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              turn_mark,
  input logic [PAIR_W-1:0] pair_s1,
  input samp_t             fir0,
  input samp_t             corr0,
  input samp_t             fir1,
  input samp_t             corr1
);
  localparam logic [PAIR_W-1:0] LAST = PAIR_W'(NPAIR - 1);

  assert_pair_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    turn_mark |=> (pair_s1 == '0));

  assert_pair_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !turn_mark |=> (pair_s1 == (($past(pair_s1) == LAST) ? '0
                                 : PAIR_W'($past(pair_s1) + 1'b1))));

  assert_zero_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fir0 == '0) |=> (corr0 == '0));

  assert_zero_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fir1 == '0) |=> (corr1 == '0));
endmodule

bind fbk_top fbk_chk #(.NPAIR(NPAIR), .PAIR_W(PAIR_W)) u_chk (
  .clk(clk), .rst_n(srst_n), .turn_mark(turn_mark), .pair_s1(pair_s1),
  .fir0(fir_w[0]), .corr0(corr_w[0]), .fir1(fir_w[1]), .corr1(corr_w[1])
);

// File: tb/fbk_top_test.sv
module fbk_top_test;
  localparam int CLK_PERIOD = 4;
  localparam int H  = 16;
  localparam int NP = H / 2;
  localparam int NT = 4;
  localparam int NSC = 5;

  localparam int SC_COEF [NSC][NT] = '{
    '{16384, 0, 0, 0},
    '{16384, -16384, 0, 0},
    '{8192, 4096, -4096, 2048},
    '{32767, 32767, 32767, 32767},
    '{-16384, 0, 8192, 0}
  };
  localparam int SC_GMODE [NSC] = '{0, 0, 1, 0, 2};
  localparam int SC_G     [NSC] = '{4096, 8192, 4096, 32767, -16384};
  localparam int SC_DLY   [NSC] = '{0, 1, 2, 3, 0};
  localparam int SC_AMP   [NSC] = '{1000, 700, 1500, 2047, 900};

  logic clk, rst_n, turn_mark, cfg_we;
  logic signed [11:0] samp_even, samp_odd, ddr_rise, ddr_fall;
  logic [7:0]  cfg_addr;
  logic [15:0] cfg_wdata;

  fbk_top #(.HARMONIC(H), .NTAPS(NT)) uut (
    .clk(clk), .rst_n(rst_n), .turn_mark(turn_mark),
    .samp_even(samp_even), .samp_odd(samp_odd),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ddr_rise(ddr_rise), .ddr_fall(ddr_fall)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp, n_bad, turn_no;
  bit done;
  int hist_m [H][NT];
  int line_m [H][3];
  int coef_m [NT];
  int gain_m [H];
  int dly_m, pair_m;
  int exp_r [3][2];
  bit exp_v [3];

  task automatic check(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rsat(input longint v, input int f);
    longint r;
    r = (v + (longint'(1) <<< (f - 1))) >>> f;
    if (r > 2047) return 2047;
    if (r < -2048) return -2048;
    return int'(r);
  endfunction

  function automatic int sine_val(input int amp, input int turn, input int b);
    real ph;
    ph = 6.283185307 * (0.11 * turn + b / 16.0);
    return $rtoi(amp * $sin(ph));
  endfunction

  task automatic model_clear();
    for (int b = 0; b < H; b++) begin
      for (int j = 0; j < NT; j++) hist_m[b][j] = 0;
      for (int d = 0; d < 3; d++) line_m[b][d] = 0;
      gain_m[b] = 0;
    end
    for (int j = 0; j < NT; j++) coef_m[j] = 0;
    dly_m = 0; pair_m = 0;
    for (int i = 0; i < 3; i++) exp_v[i] = 1'b0;
  endtask

  // one cycle, entered and left at a falling edge
  task automatic cyc(input int x0, input int x1, input bit mark, input bit we,
                     input int addr, input int data, input string tag);
    int p, b, f, c, o, xs;
    longint acc;
    if (exp_v[2]) begin
      check(int'(ddr_rise), exp_r[2][0], {tag, " R6 rise"});
      check(int'(ddr_fall), exp_r[2][1], {tag, " R6 fall"});
    end
    exp_r[2] = exp_r[1]; exp_v[2] = exp_v[1];
    exp_r[1] = exp_r[0]; exp_v[1] = exp_v[0];
    p = mark ? 0 : pair_m;
    for (int l = 0; l < 2; l++) begin
      b  = 2 * p + l;
      xs = (l == 0) ? x0 : x1;
      for (int j = NT - 1; j > 0; j--) hist_m[b][j] = hist_m[b][j-1];
      hist_m[b][0] = xs;
      acc = 0;
      for (int j = 0; j < NT; j++) acc += longint'(coef_m[j]) * hist_m[b][j];
      f = rsat(acc, 14);
      c = rsat(longint'(f) * gain_m[b], 12);
      o = (dly_m == 0) ? c : line_m[b][dly_m-1];
      line_m[b][2] = line_m[b][1];
      line_m[b][1] = line_m[b][0];
      line_m[b][0] = c;
      exp_r[0][l] = o;
    end
    exp_v[0] = 1'b1;
    pair_m = (p == NP - 1) ? 0 : p + 1;
    if (we) begin
      if (addr < NT) coef_m[addr] = int'($signed(16'(data)));
      else if (addr == 8'h40) dly_m = data & 3;
      else if (addr >= 8'h80 && addr < 8'h80 + H)
        gain_m[addr-8'h80] = int'($signed(16'(data)));
    end
    samp_even = 12'(x0); samp_odd = 12'(x1); turn_mark = mark;
    cfg_we = we; cfg_addr = 8'(addr); cfg_wdata = 16'(data);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int addr, input int data);
    cyc(0, 0, 1'b0, 1'b1, addr, data, "R7 write");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; turn_mark = 0; cfg_we = 0; samp_even = 0; samp_odd = 0;
    cfg_addr = 0; cfg_wdata = 0;
    model_clear();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(int'(ddr_rise), 0, "R1 rise in reset");
    check(int'(ddr_fall), 0, "R1 fall in reset");
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(int'(ddr_rise), 0, "R1 rise after release");
    check(int'(ddr_fall), 0, "R1 fall after release");
  endtask

  task automatic stream(input int amp, input int turns, input string tag);
    for (int t = 0; t < turns; t++) begin
      for (int p = 0; p < NP; p++)
        cyc(sine_val(amp, turn_no, 2 * p), sine_val(amp, turn_no, 2 * p + 1),
            p == 0, 1'b0, 0, 0, tag);
      turn_no++;
    end
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; turn_no = 0; done = 0;
    rst_n = 1'b0;
    do_reset();

    // scenario table walk: R3 filter, R4 gains, R5 delay, R8 clamp
    for (int s = 0; s < NSC; s++) begin
      string tag;
      int g;
      case (s)
        0: tag = "R3 pass-through";
        1: tag = "R5 one-turn delay";
        2: tag = "R4 alternating gain";
        3: tag = "R8 clamp";
        default: tag = "R4 single bunch";
      endcase
      for (int j = 0; j < NT; j++) wr(j, SC_COEF[s][j]);
      wr(8'h40, SC_DLY[s]);
      for (int b = 0; b < H; b++) begin
        case (SC_GMODE[s])
          0: g = SC_G[s];
          1: g = (b % 2 == 0) ? SC_G[s] : -SC_G[s] / 2;
          default: g = (b == 5) ? SC_G[s] : 0;
        endcase
        wr(8'h80 + b, g);
      end
      stream(SC_AMP[s], 6, tag);
    end

    // R2: early turn marker in the middle of a turn
    for (int p = 0; p < 3; p++) cyc(100 + p, -50 - p, p == 0, 0, 0, 0, "R2 early mark");
    cyc(333, -333, 1'b1, 0, 0, 0, "R2 early mark");
    stream(800, 2, "R2 after early mark");

    // R7: unmapped writes inside a running stream; R5: delay field low bits
    cyc(200, 300, 1'b0, 1'b1, 8'h50, 16'h7fff, "R7 unmapped");
    cyc(210, 310, 1'b0, 1'b1, 8'h80 + H, 16'h7fff, "R7 past gain table");
    cyc(220, 320, 1'b0, 1'b1, 8'h04, 16'h7fff, "R7 past coef range");
    cyc(230, 330, 1'b0, 1'b1, 8'h40, 16'hfffd, "R5 delay low bits");
    stream(600, 3, "R5 delay after write");

    // R3: rounding half up of a half-scale coefficient
    wr(0, 8192); wr(1, 0); wr(2, 0); wr(3, 0); wr(8'h40, 0);
    for (int b = 0; b < H; b++) wr(8'h80 + b, 4096);
    for (int i = 0; i < 2 * NP; i++) cyc(3, -3, 1'b0, 0, 0, 0, "R3 rounding");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1'b0, 0, 0, 0, "R3 flush");

    // R1: reset in the middle of a stream clears everything
    stream(900, 1, "R1 before reset");
    do_reset();
    wr(8'h80, 4096); wr(8'h81, 4096);
    stream(500, 2, "R1 cleared coefficients");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1'b0, 0, 0, 0, "R6 flush");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule